// File: doc/BRIEF.md
# Cipher Context Length Tracker

This block keeps the two byte counts that describe one cipher context: the payload count and the count of authentication-only bytes. Software fills three length slots through a small write port. A write to one slot launches the context, and which slot does so depends on the mode class. Basic block modes launch on the payload high word. The two combined authenticated modes, a Galois-hash mode and a counter-with-MAC mode, launch on the authentication count. At launch the block checks the programmed counts against the limits of the selected mode. It either emits a one-cycle start pulse and loads its down-counters, or raises a sticky error and stays quiet.

While a context runs, the datapath sends one consume strobe per 16-byte block, together with the number of valid bytes in that block, so a short final block is counted in whole bytes. Authentication-only bytes are used up first, then payload bytes. A last-block flag tells the datapath when the active phase has at most one block left. In basic modes a payload count of zero means an endless stream, and the payload counter then never moves. Reads of the length slots always return zero.

Top module: `cipher_len_track`

## Requirements
- R1: After reset, start, last_blk, endless, len_err, rd_ack, pay_left and auth_left are all zero.
- R2: With mode 0 (basic), a write to slot 1 (payload high word, bits 28:0 used) launches the context. The payload count is {slot 1 data, slot 0 data}, where slot 0 is the low 32 bits. start is high for exactly the cycle after the write, pay_left shows the count in that same cycle, and auth_left is 0.
- R3: With mode 1 (GCM) or mode 2 (CCM), a write to slot 2 (authentication count, 32 bits) launches the context with the staged payload count. A write to slot 1 in these modes gives no start.
- R4: In mode 0 a zero payload count sets endless. While endless is set, consume strobes leave pay_left at 0 and last_blk stays 0. The next launch clears endless.
- R5: Each consume strobe subtracts its byte count from auth_left while auth_left is nonzero, and otherwise from pay_left, saturating at 0. A byte field of 0 or more than 16 counts as 16.
- R6: last_blk is 1 when the active phase (authentication if auth_left is nonzero, else payload) has between 1 and 16 bytes left, and 0 otherwise.
- R7: In CCM mode an authentication count above 0xFF00 (2^16 - 2^8) gives no start and sets len_err. Exactly 0xFF00 is accepted.
- R8: In GCM mode a payload count above 2^36 - 32 gives no start and sets len_err. Exactly 2^36 - 32 is accepted.
- R9: In GCM or CCM mode, a launch with both counts zero gives no start and sets len_err.
- R10: len_err stays set until reset, and a later valid launch still starts. A launch in mode 3 (reserved, triggered on slot 1) is rejected with len_err. A rejected launch leaves the running counts as they were.
- R11: A read strobe returns rd_ack one cycle later, with rd_data equal to zero.
- R12: Consume strobes arriving when both counts are zero and endless is clear change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Length slot write strobe |
| wr_addr | input | 2 | Slot: 0 payload low, 1 payload high, 2 auth count |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Length slot read strobe |
| rd_data | output | 32 | Read data (always zero) |
| rd_ack | output | 1 | Read response strobe |
| mode | input | 2 | 0 basic, 1 GCM, 2 CCM, 3 reserved |
| blk_take | input | 1 | One block consumed |
| blk_bytes | input | 5 | Valid bytes in the consumed block (0 means 16) |
| start | output | 1 | One-cycle launch pulse |
| pay_left | output | 61 | Remaining payload bytes |
| auth_left | output | 32 | Remaining authentication-only bytes |
| last_blk | output | 1 | Active phase has at most one block left |
| endless | output | 1 | Basic-mode infinite stream |
| len_err | output | 1 | Sticky length violation |

## Verification
The bench probes each limit at its exact boundary and one step past it: CCM authentication at 0xFF00 and 0xFF01, and GCM payload at 2^36-32 and 2^36-16. An off-by-one comparison would then show up as a wrongly accepted or wrongly rejected launch. It writes the payload high word in a combined mode, and a wrong trigger decode would answer that with a spurious start. A mixed run with a short authentication block and partial payload blocks shows whether the phase order or the partial-byte subtraction is wrong, since pay_left would then move too early or by 16. Endless streams, consumes after completion, and a valid launch after an error show whether counts drift or the error flag clears itself.

// File: rtl/clt_pkg.sv
package clt_pkg;

    localparam int WORD_W    = 32;
    localparam int PAY_W     = 61;
    localparam int AUTH_W    = 32;
    localparam int BLK_BYTES = 16;
    localparam int AMT_W     = $clog2(BLK_BYTES + 1);
    localparam int HI_W      = PAY_W - WORD_W;

    typedef enum logic [1:0] {
        MODE_BASIC = 2'd0,
        MODE_GCM   = 2'd1,
        MODE_CCM   = 2'd2,
        MODE_RSVD  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SLOT_PAY_LO = 2'd0,
        SLOT_PAY_HI = 2'd1,
        SLOT_AUTH   = 2'd2,
        SLOT_NONE   = 2'd3
    } slot_e;

    localparam logic [PAY_W-1:0]  GCM_PAY_MAX  = (PAY_W'(1) << 36) - PAY_W'(32);
    localparam logic [AUTH_W-1:0] CCM_AUTH_MAX = (AUTH_W'(1) << 16) - (AUTH_W'(1) << 8);

    typedef struct packed {
        logic [PAY_W-1:0]  pay;
        logic [AUTH_W-1:0] auth;
        logic              endless;
    } ctx_t;

    // bytes field: 0 or anything above a full block means a full block
    function automatic logic [AMT_W-1:0] clamp_amt(input logic [AMT_W-1:0] b);
        if (b == '0 || b > AMT_W'(BLK_BYTES))
            return AMT_W'(BLK_BYTES);
        return b;
    endfunction

endpackage

// File: rtl/clt_ctx_regs.sv
module clt_ctx_regs
    import clt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  slot_e             wr_slot,
    input  logic [WORD_W-1:0] wr_data,
    input  mode_e             mode,
    output logic              trig,
    output logic              ok,
    output ctx_t              ctx
);
    logic [WORD_W-1:0] pay_lo_q;
    logic [HI_W-1:0]   pay_hi_q;
    logic              combined;
    logic              both_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            pay_lo_q <= '0;
            pay_hi_q <= '0;
        end else if (wr_en) begin
            case (wr_slot)
                SLOT_PAY_LO: pay_lo_q <= wr_data;
                SLOT_PAY_HI: pay_hi_q <= wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        combined = (mode == MODE_GCM) || (mode == MODE_CCM);
        trig     = wr_en && (combined ? (wr_slot == SLOT_AUTH) : (wr_slot == SLOT_PAY_HI));
        if (combined) begin
            ctx.pay  = {pay_hi_q, pay_lo_q};
            ctx.auth = wr_data;
        end else begin
            ctx.pay  = {wr_data[HI_W-1:0], pay_lo_q};
            ctx.auth = '0;
        end
        ctx.endless = !combined && (ctx.pay == '0);
        both_zero   = (ctx.pay == '0) && (ctx.auth == '0);
        case (mode)
            MODE_BASIC: ok = 1'b1;
            MODE_GCM:   ok = !both_zero && (ctx.pay <= GCM_PAY_MAX);
            MODE_CCM:   ok = !both_zero && (ctx.auth <= CCM_AUTH_MAX);
            default:    ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/clt_down_cnt.sv
module clt_down_cnt
    import clt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [W-1:0]     load_val,
    input  logic             dec,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     cnt
);
    logic [W-1:0] amt_w;

    assign amt_w = W'(amt);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= (cnt > amt_w) ? (cnt - amt_w) : '0;
    end

    // R5: without a load the count never rises
    a_r5_no_rise: assert property (@(posedge clk) disable iff (rst)
        !load |=> cnt <= $past(cnt));

    // R5: a decrement never removes more than one block of bytes
    a_r5_step_bound: assert property (@(posedge clk) disable iff (rst)
        (!load && dec) |=> ($past(cnt) - cnt) <= W'(BLK_BYTES));

endmodule

// File: rtl/cipher_len_track.sv
module cipher_len_track
    import clt_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_PAY_W  = PAY_W,
    parameter int P_AUTH_W = AUTH_W,
    parameter int P_AMT_W  = AMT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [P_WORD_W-1:0] wr_data,
    input  logic                rd_en,
    output logic [P_WORD_W-1:0] rd_data,
    output logic                rd_ack,
    input  logic [1:0]          mode,
    input  logic                blk_take,
    input  logic [P_AMT_W-1:0]  blk_bytes,
    output logic                start,
    output logic [P_PAY_W-1:0]  pay_left,
    output logic [P_AUTH_W-1:0] auth_left,
    output logic                last_blk,
    output logic                endless,
    output logic                len_err
);
    logic             trig, ok, load;
    ctx_t             ctx;
    logic             auth_nz, pay_nz;
    logic             dec_auth, dec_pay;
    logic [AMT_W-1:0] amt;

    clt_ctx_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_slot (slot_e'(wr_addr)),
        .wr_data (wr_data),
        .mode    (mode_e'(mode)),
        .trig    (trig),
        .ok      (ok),
        .ctx     (ctx)
    );

    assign load     = trig && ok;
    assign auth_nz  = (auth_left != '0);
    assign pay_nz   = (pay_left != '0);
    assign amt      = clamp_amt(blk_bytes);
    assign dec_auth = blk_take && !load && auth_nz;
    assign dec_pay  = blk_take && !load && !auth_nz && pay_nz && !endless;

    clt_down_cnt #(.W(PAY_W)) u_pay (
        .clk (clk), .rst (rst), .load (load), .load_val (ctx.pay),
        .dec (dec_pay), .amt (amt), .cnt (pay_left)
    );

    clt_down_cnt #(.W(AUTH_W)) u_auth (
        .clk (clk), .rst (rst), .load (load), .load_val (ctx.auth),
        .dec (dec_auth), .amt (amt), .cnt (auth_left)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start   <= 1'b0;
            len_err <= 1'b0;
            endless <= 1'b0;
            rd_ack  <= 1'b0;
            rd_data <= '0;
        end else begin
            start   <= load;
            len_err <= len_err || (trig && !ok);
            if (load)
                endless <= ctx.endless;
            rd_ack  <= rd_en;
            rd_data <= '0;
        end
    end

    always_comb begin
        if (auth_nz)
            last_blk = (auth_left <= AUTH_W'(BLK_BYTES));
        else
            last_blk = !endless && pay_nz && (pay_left <= PAY_W'(BLK_BYTES));
    end

    // R10: error flag never clears on its own
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        len_err |=> len_err);

    // R7: a rejected launch never produces a start pulse
    a_r7_no_start_on_bad: assert property (@(posedge clk) disable iff (rst)
        (trig && !ok) |=> !start);

    // R4: an endless stream holds the payload count still
    a_r4_endless_hold: assert property (@(posedge clk) disable iff (rst)
        (endless && !load) |=> $stable(pay_left));

    // R6: last-block flag only with bytes left
    a_r6_last_needs_bytes: assert property (@(posedge clk) disable iff (rst)
        last_blk |-> (auth_nz || pay_nz));

    // R5: payload does not move while authentication bytes remain
    a_r5_auth_first: assert property (@(posedge clk) disable iff (rst)
        (auth_nz && !load) |=> $stable(pay_left));

endmodule

// File: tb/cipher_len_track_test.sv
module cipher_len_track_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_ack;
    logic [1:0]  mode = '0;
    logic        blk_take = 1'b0;
    logic [4:0]  blk_bytes = '0;
    logic        start;
    logic [60:0] pay_left;
    logic [31:0] auth_left;
    logic        last_blk, endless, len_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { logic [60:0] pay; logic [31:0] auth; } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    cipher_len_track uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_ack(rd_ack), .mode(mode),
        .blk_take(blk_take), .blk_bytes(blk_bytes), .start(start),
        .pay_left(pay_left), .auth_left(auth_left), .last_blk(last_blk),
        .endless(endless), .len_err(len_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every start pulse must match the oldest expected launch
    always @(negedge clk) begin
        if (!rst && start) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R3 unexpected start actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check("R2 start pay_left", 64'(pay_left), 64'(e.pay));
                check("R3 start auth_left", 64'(auth_left), 64'(e.auth));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // driver: a write that should launch, with its expected loaded counts
    task automatic wr_go(input logic [1:0] a, input logic [31:0] d,
                         input logic [60:0] ep, input logic [31:0] ea);
        exp_t e;
        e.pay = ep; e.auth = ea;
        sb.push_back(e);
        wr(a, d);
        check("R2 start pulse", 64'(start), 64'd1);
    endtask

    task automatic wr_nogo(input string tag, input logic [1:0] a, input logic [31:0] d);
        wr(a, d);
        check(tag, 64'(start), 64'd0);
    endtask

    task automatic take(input logic [4:0] b);
        @(negedge clk); blk_take = 1'b1; blk_bytes = b;
        @(negedge clk); blk_take = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check("R1 start", 64'(start), 0);
        check("R1 pay_left", 64'(pay_left), 0);
        check("R1 auth_left", 64'(auth_left), 0);
        check("R1 last_blk", 64'(last_blk), 0);
        check("R1 endless", 64'(endless), 0);
        check("R1 len_err", 64'(len_err), 0);
        // R11 reads return zero
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check("R11 rd_ack", 64'(rd_ack), 1);
        check("R11 rd_data", 64'(rd_data), 0);

        // R2 basic launch, 256 bytes
        mode = 2'd0;
        wr(2'd0, 32'h100);
        wr_go(2'd1, 32'h0, 61'h100, 32'h0);
        @(negedge clk);
        check("R2 single-cycle start", 64'(start), 0);
        check("R6 not last", 64'(last_blk), 0);
        take(5'd0);  // R5 field 0 counts as 16
        check("R5 zero field is 16", 64'(pay_left), 64'hF0);
        for (int i = 0; i < 14; i++) take(5'd16);
        check("R6 pay 16 left", 64'(pay_left), 64'h10);
        check("R6 last_blk on final block", 64'(last_blk), 1);
        take(5'd16);
        check("R5 pay done", 64'(pay_left), 0);
        check("R6 last clear at zero", 64'(last_blk), 0);
        take(5'd16);
        check("R12 idle take ignored", 64'(pay_left), 0);
        check("R12 idle auth", 64'(auth_left), 0);

        // R2 high word
        wr(2'd0, 32'h20);
        wr_go(2'd1, 32'h1, 61'h1_0000_0020, 32'h0);

        // R3 GCM: slot 1 does not launch, slot 2 does
        mode = 2'd1;
        wr(2'd0, 32'd40);
        wr_nogo("R3 slot1 in GCM no start", 2'd1, 32'h0);
        wr_go(2'd2, 32'd20, 61'd40, 32'd20);
        take(5'd16);
        check("R5 auth first", 64'(auth_left), 4);
        check("R5 pay untouched", 64'(pay_left), 40);
        check("R6 last in auth phase", 64'(last_blk), 1);
        take(5'd4);
        check("R5 auth partial", 64'(auth_left), 0);
        check("R6 pay phase not last", 64'(last_blk), 0);
        take(5'd16);
        take(5'd16);
        check("R5 pay 8 left", 64'(pay_left), 8);
        check("R6 last partial", 64'(last_blk), 1);
        take(5'd8);
        check("R5 pay exhausted", 64'(pay_left), 0);

        // R4 endless basic stream
        mode = 2'd0;
        wr(2'd0, 32'h0);
        wr_go(2'd1, 32'h0, 61'h0, 32'h0);
        check("R4 endless set", 64'(endless), 1);
        take(5'd16);
        take(5'd3);
        check("R4 pay stays 0", 64'(pay_left), 0);
        check("R4 no last", 64'(last_blk), 0);
        check("R4 still endless", 64'(endless), 1);

        // R7 CCM limit
        mode = 2'd2;
        wr_nogo("R3 slot1 in CCM no start", 2'd1, 32'h0);
        wr_go(2'd2, 32'hFF00, 61'h0, 32'hFF00);
        check("R4 endless cleared", 64'(endless), 0);
        check("R7 boundary accepted", 64'(len_err), 0);
        wr_nogo("R7 over limit no start", 2'd2, 32'hFF01);
        check("R7 err set", 64'(len_err), 1);
        check("R10 counts kept", 64'(auth_left), 64'hFF00);
        wr_go(2'd2, 32'h10, 61'h0, 32'h10);
        check("R10 err sticky", 64'(len_err), 1);
        do_reset();
        check("R10 reset clears err", 64'(len_err), 0);

        // R8 GCM payload limit
        mode = 2'd1;
        wr(2'd0, 32'hFFFF_FFE0);
        wr(2'd1, 32'hF);
        wr_go(2'd2, 32'h0, 61'hF_FFFF_FFE0, 32'h0);
        check("R8 boundary accepted", 64'(len_err), 0);
        wr(2'd0, 32'hFFFF_FFF0);
        wr_nogo("R8 over limit no start", 2'd2, 32'h0);
        check("R8 err set", 64'(len_err), 1);
        do_reset();

        // R9 both zero in combined mode
        mode = 2'd1;
        wr_nogo("R9 no start", 2'd2, 32'h0);
        check("R9 err set", 64'(len_err), 1);
        do_reset();

        // R10 reserved mode
        mode = 2'd3;
        wr(2'd0, 32'h5);
        wr_nogo("R10 reserved no start", 2'd1, 32'h0);
        check("R10 reserved err", 64'(len_err), 1);

        repeat (3) @(negedge clk);
        check("R3 scoreboard drained", 64'(sb.size()), 0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule